// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block is the transmit engine of a synchronous serial port. It advances only on clock cycles where the transmit clock enable `tick` is high, and it has two outputs: the serial data line and an active-high frame sync. Between frames the data line rests at a programmable idle level. When a start is accepted, the block sends a frame sync pulse whose length is a base field plus sixteen times an extension field, plus one. During the pulse the data line can carry bits of a sync word. Immediately after the pulse, the block serializes a programmable number of data words back to back. Each word has a programmable bit count and bit order.

Data words come in through a request/valid handshake. The block raises `word_req` one transmit period before a word is needed and samples `word_data` on the tick that begins that word. If no word is offered at that tick, the block flags an underrun and sends the previous word again. The block captures all configuration and the sync word when a frame starts, so configuration writes made during a frame apply only to the next frame. A start request with a zero data-length field is refused and flagged as a configuration error.

Top module: `sstx_top`

## Requirements
- R1: After reset, `tx_fs`, `busy`, `word_req`, `underrun` and `cfg_err` are all 0.
- R2: While no frame is running, `tx_data` equals `cfg_idle_level` and follows it within one clock.
- R3: A start is accepted only on a clock with `tick`=1 while idle and `cfg_wlen_m1`≠0. `tx_fs` and `busy` rise on that clock edge.
- R4: `tx_fs` stays high for exactly `cfg_fs_base + 16*cfg_fs_ext + 1` ticks. The first data bit appears on the tick after the pulse ends, and `tx_fs` is 0 while data bits are sent.
- R5: With `cfg_sync_en`=1, pulse tick i (counting from 0) carries `sync_word[i]`, so the sync word goes out LSB first. Pulse ticks at index 16 or above carry the idle level. With `cfg_sync_en`=0, the line holds the idle level for the whole pulse.
- R6: Each word sends N = `cfg_wlen_m1`+1 bits. With `cfg_msb_first`=0 the order is bit 0 up to bit N-1. With `cfg_msb_first`=1 the order is bit N-1 down to bit 0. Bits at N and above are never sent.
- R7: A frame sends `cfg_words_m1`+1 words with no gaps between them. On the tick after the last bit, `tx_fs` and `busy` are 0 and the line returns to idle.
- R8: `word_req` rises on the tick that begins the last bit of the sync pulse or of a word that has a successor. It falls on the next tick, which is the tick where `word_data` is taken if `word_valid`=1.
- R9: If `word_valid`=0 on a loading tick, `underrun` pulses for one clock and the previous word of the frame is sent again.
- R10: A start with `cfg_wlen_m1`=0 pulses `cfg_err` for one clock, produces no frame, and leaves the line idle.
- R11: A start during a frame is ignored, and no second frame follows.
- R12: Configuration and `sync_word` are captured at the start of a frame. Changes made during the frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Transmit clock enable; one serial bit period per high cycle |
| start | input | 1 | Frame start request, taken when `tick` is high |
| cfg_wlen_m1 | input | 5 | Bits per word minus one (0 is illegal) |
| cfg_words_m1 | input | 4 | Words per frame minus one |
| cfg_fs_base | input | 4 | Frame sync length, base part |
| cfg_fs_ext | input | 4 | Frame sync length, extension part (weight 16) |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_sync_en | input | 1 | Send the sync word during the frame sync pulse |
| cfg_idle_level | input | 1 | Data line level outside frames |
| sync_word | input | 16 | Sync data bits |
| word_data | input | 32 | Next data word |
| word_valid | input | 1 | `word_data` is available |
| word_req | output | 1 | Next word needed on the coming tick |
| underrun | output | 1 | One-clock pulse: word missing at load |
| cfg_err | output | 1 | One-clock pulse: start refused, zero data length |
| busy | output | 1 | Frame in progress |
| tx_data | output | 1 | Serial data line |
| tx_fs | output | 1 | Frame sync, active high |

## Verification
A wrong bit or word counter appears at the ports on the very tick where it diverges. Depending on the fault, the frame sync edge moves, a bit is missing or repeated, or the frame runs too long or too short. A bench that compares the line against an expected stream after every tick therefore catches it on that tick. A wrong index into a word or into the sync word shows up as a wrong data bit within that word's period. A request flag that fails to clear, or that is set on the wrong tick, is seen one tick before or at the load. A wrong held word is visible only when an underrun forces a resend, so frames with withheld words are included.

// File: rtl/sstx_pkg.sv
// Package: shared types and constants for the serial frame transmitter.
// Assumes: used by all sstx_* modules.
package sstx_pkg;
    // Frame phases of the transmit sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2
    } tx_state_e;

    // The extension field of the sync length carries this binary weight.
    localparam int FS_EXT_SHIFT = 4;
endpackage

// File: rtl/sstx_seq.sv
// Module: frame sequencer. Tracks the frame phase and the sync, bit and
// word counters. Captures configuration when a frame starts and issues
// load and request events for the word buffer.
// Assumes: every state change happens on a clock with tick high; start is
// sampled only on such clocks.
module sstx_seq
    import sstx_pkg::*;
#(
    parameter int LEN_W = 5,
    parameter int CNT_W = 4,
    parameter int FSB_W = 4,
    parameter int FSE_W = 4,
    parameter int FS_CW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [LEN_W-1:0] cfg_wlen_m1,
    input  logic [CNT_W-1:0] cfg_words_m1,
    input  logic [FSB_W-1:0] cfg_fs_base,
    input  logic [FSE_W-1:0] cfg_fs_ext,
    input  logic             cfg_msb_first,
    input  logic             cfg_sync_en,
    input  logic             cfg_idle_level,
    output tx_state_e        state_q,
    output tx_state_e        nxt_state,
    output logic [FS_CW-1:0] nxt_cnt,
    output logic [LEN_W-1:0] nxt_bit,
    output logic [LEN_W-1:0] nxt_wlen,
    output logic             nxt_msb,
    output logic             nxt_sen,
    output logic             nxt_idle,
    output logic             start_ok,
    output logic             load,
    output logic             req_set,
    output logic             cfg_err
);
    localparam logic [FS_CW-1:0] CNT_ONE = FS_CW'(1);
    localparam logic [LEN_W-1:0] BIT_ONE = LEN_W'(1);
    localparam logic [CNT_W-1:0] WRD_ONE = CNT_W'(1);

    logic [FS_CW-1:0] cnt_q, len_q, nxt_len, fs_len_m1;
    logic [LEN_W-1:0] bit_q, wlen_q;
    logic [CNT_W-1:0] word_q, words_q, nxt_word, nxt_words;
    logic             msb_q, sen_q, idle_q, err_q;
    logic             bad_start, sync_end, bit_end, last_word;

    // Pulse length minus one, from the base and extension fields.
    assign fs_len_m1 = FS_CW'(cfg_fs_base) + (FS_CW'(cfg_fs_ext) << FS_EXT_SHIFT);

    // Event decode for the current clock.
    assign start_ok  = tick && start && (state_q == ST_IDLE) && (cfg_wlen_m1 != '0);
    assign bad_start = tick && start && (state_q == ST_IDLE) && (cfg_wlen_m1 == '0);
    assign sync_end  = tick && (state_q == ST_SYNC) && (cnt_q == len_q);
    assign bit_end   = tick && (state_q == ST_DATA) && (bit_q == wlen_q);
    assign last_word = (word_q == words_q);
    assign load      = sync_end || (bit_end && !last_word);

    // A request is raised on the tick that begins the last bit before a load.
    assign req_set = (start_ok && (fs_len_m1 == '0))
                  || (tick && (state_q == ST_SYNC) && (cnt_q + CNT_ONE == len_q))
                  || (tick && (state_q == ST_DATA) && !last_word && (bit_q + BIT_ONE == wlen_q));

    // Next-state and next-counter computation.
    always_comb begin
        nxt_state = state_q;
        nxt_cnt   = cnt_q;
        nxt_bit   = bit_q;
        nxt_word  = word_q;
        nxt_len   = len_q;
        nxt_wlen  = wlen_q;
        nxt_words = words_q;
        nxt_msb   = msb_q;
        nxt_sen   = sen_q;
        nxt_idle  = idle_q;
        if (start_ok) begin
            nxt_state = ST_SYNC;
            nxt_cnt   = '0;
            nxt_len   = fs_len_m1;
            nxt_wlen  = cfg_wlen_m1;
            nxt_words = cfg_words_m1;
            nxt_msb   = cfg_msb_first;
            nxt_sen   = cfg_sync_en;
            nxt_idle  = cfg_idle_level;
        end else if (sync_end) begin
            nxt_state = ST_DATA;
            nxt_bit   = '0;
            nxt_word  = '0;
        end else if (bit_end) begin
            if (last_word) begin
                nxt_state = ST_IDLE;
            end else begin
                nxt_bit  = '0;
                nxt_word = word_q + WRD_ONE;
            end
        end else if (tick && (state_q == ST_SYNC)) begin
            nxt_cnt = cnt_q + CNT_ONE;
        end else if (tick && (state_q == ST_DATA)) begin
            nxt_bit = bit_q + BIT_ONE;
        end
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            word_q  <= '0;
            len_q   <= '0;
            wlen_q  <= '0;
            words_q <= '0;
            msb_q   <= 1'b0;
            sen_q   <= 1'b0;
            idle_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= nxt_state;
            cnt_q   <= nxt_cnt;
            bit_q   <= nxt_bit;
            word_q  <= nxt_word;
            len_q   <= nxt_len;
            wlen_q  <= nxt_wlen;
            words_q <= nxt_words;
            msb_q   <= nxt_msb;
            sen_q   <= nxt_sen;
            idle_q  <= nxt_idle;
            err_q   <= bad_start;
        end
    end

    assign cfg_err = err_q;

    a_r4_sync_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC) |-> (cnt_q <= len_q));
    a_r6_bit_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> ((bit_q <= wlen_q) && (wlen_q != '0)));
    a_r7_word_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (word_q <= words_q));
    a_r3_sync_before_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q != ST_DATA));
    a_r12_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE))
            |-> ($stable(wlen_q) && $stable(words_q) && $stable(len_q) && $stable(msb_q)));
endmodule

// File: rtl/sstx_word_buf.sv
// Module: word holding register with the request/valid handshake.
// Takes a new word on each load event when one is offered. Otherwise it
// keeps the old word and reports an underrun.
// Assumes: load and req_set never occur on the same clock.
module sstx_word_buf #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              req_set,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic [WORD_W-1:0] nxt_word,
    output logic              word_req,
    output logic              underrun
);
    logic [WORD_W-1:0] hold_q;
    logic              req_q, under_q;

    // Word that is current after this clock.
    assign nxt_word = (load && word_valid) ? word_data : hold_q;

    // Holding register, request flag and underrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            req_q   <= 1'b0;
            under_q <= 1'b0;
        end else begin
            hold_q  <= nxt_word;
            under_q <= load && !word_valid;
            if (req_set) begin
                req_q <= 1'b1;
            end else if (load) begin
                req_q <= 1'b0;
            end
        end
    end

    assign word_req = req_q;
    assign underrun = under_q;

    a_r8_request_precedes_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> req_q);
    a_r9_underrun_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        under_q |-> $past(req_q));
endmodule

// File: rtl/sstx_bit_sel.sv
// Module: output bit selection and output registers. From the sequencer's
// next state it picks the idle level, a sync bit or a data bit, and
// registers the data and frame sync lines.
// Assumes: WORD_W is at least 2**LEN_W; the sync word goes out LSB first.
module sstx_bit_sel
    import sstx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 5,
    parameter int FS_CW  = 9,
    parameter int SYNC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic [SYNC_W-1:0] sync_word,
    input  tx_state_e         nxt_state,
    input  logic [FS_CW-1:0]  nxt_cnt,
    input  logic [LEN_W-1:0]  nxt_bit,
    input  logic [LEN_W-1:0]  nxt_wlen,
    input  logic              nxt_msb,
    input  logic              nxt_sen,
    input  logic              nxt_idle,
    input  logic              cfg_idle_level,
    input  logic [WORD_W-1:0] nxt_word,
    output logic              tx_data,
    output logic              tx_fs
);
    localparam int SIDX_W = (SYNC_W > 1) ? $clog2(SYNC_W) : 1;

    logic [SYNC_W-1:0] sync_q, nxt_sync;
    logic [LEN_W-1:0]  widx;
    logic              in_range, sync_bit, data_bit, sel_bit;
    logic              data_q, fs_q;

    assign nxt_sync = start_ok ? sync_word : sync_q;

    // A sync word that covers the longest pulse needs no range test.
    if (SYNC_W >= (1 << FS_CW)) begin : g_sync_full
        assign in_range = 1'b1;
    end else begin : g_sync_lim
        assign in_range = (nxt_cnt < FS_CW'(SYNC_W));
    end

    assign sync_bit = in_range ? nxt_sync[nxt_cnt[SIDX_W-1:0]] : nxt_idle;
    assign widx     = nxt_msb ? (nxt_wlen - nxt_bit) : nxt_bit;
    assign data_bit = nxt_word[widx];

    // Line level for the coming clock, chosen by phase.
    always_comb begin
        case (nxt_state)
            ST_SYNC: sel_bit = nxt_sen ? sync_bit : nxt_idle;
            ST_DATA: sel_bit = data_bit;
            default: sel_bit = cfg_idle_level;
        endcase
    end

    // Output registers and the sync word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            data_q <= 1'b0;
            fs_q   <= 1'b0;
        end else begin
            sync_q <= nxt_sync;
            data_q <= sel_bit;
            fs_q   <= (nxt_state == ST_SYNC);
        end
    end

    assign tx_data = data_q;
    assign tx_fs   = fs_q;
endmodule

// File: rtl/sstx_top.sv
// Module: top of the synchronous serial frame transmitter. Connects the
// sequencer, the word buffer and the output bit selection.
// Assumes: tick is synchronous to clk; configuration is stable on the clock
// where a start is accepted.
module sstx_top #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 5,
    parameter int CNT_W  = 4,
    parameter int FSB_W  = 4,
    parameter int FSE_W  = 4,
    parameter int SYNC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [LEN_W-1:0]  cfg_wlen_m1,
    input  logic [CNT_W-1:0]  cfg_words_m1,
    input  logic [FSB_W-1:0]  cfg_fs_base,
    input  logic [FSE_W-1:0]  cfg_fs_ext,
    input  logic              cfg_msb_first,
    input  logic              cfg_sync_en,
    input  logic              cfg_idle_level,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_valid,
    output logic              word_req,
    output logic              underrun,
    output logic              cfg_err,
    output logic              busy,
    output logic              tx_data,
    output logic              tx_fs
);
    import sstx_pkg::*;

    localparam int EXT_TOP = FSE_W + FS_EXT_SHIFT;
    localparam int FS_CW   = ((FSB_W > EXT_TOP) ? FSB_W : EXT_TOP) + 1;

    tx_state_e         state_q, nxt_state;
    logic [FS_CW-1:0]  nxt_cnt;
    logic [LEN_W-1:0]  nxt_bit, nxt_wlen;
    logic              nxt_msb, nxt_sen, nxt_idle;
    logic              start_ok, load, req_set;
    logic [WORD_W-1:0] nxt_word;

    sstx_seq #(
        .LEN_W(LEN_W), .CNT_W(CNT_W), .FSB_W(FSB_W), .FSE_W(FSE_W), .FS_CW(FS_CW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .cfg_wlen_m1(cfg_wlen_m1), .cfg_words_m1(cfg_words_m1),
        .cfg_fs_base(cfg_fs_base), .cfg_fs_ext(cfg_fs_ext),
        .cfg_msb_first(cfg_msb_first), .cfg_sync_en(cfg_sync_en),
        .cfg_idle_level(cfg_idle_level),
        .state_q(state_q), .nxt_state(nxt_state), .nxt_cnt(nxt_cnt),
        .nxt_bit(nxt_bit), .nxt_wlen(nxt_wlen), .nxt_msb(nxt_msb),
        .nxt_sen(nxt_sen), .nxt_idle(nxt_idle), .start_ok(start_ok),
        .load(load), .req_set(req_set), .cfg_err(cfg_err)
    );

    sstx_word_buf #(.WORD_W(WORD_W)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .load(load), .req_set(req_set),
        .word_valid(word_valid), .word_data(word_data),
        .nxt_word(nxt_word), .word_req(word_req), .underrun(underrun)
    );

    sstx_bit_sel #(
        .WORD_W(WORD_W), .LEN_W(LEN_W), .FS_CW(FS_CW), .SYNC_W(SYNC_W)
    ) u_bsel (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .sync_word(sync_word),
        .nxt_state(nxt_state), .nxt_cnt(nxt_cnt), .nxt_bit(nxt_bit),
        .nxt_wlen(nxt_wlen), .nxt_msb(nxt_msb), .nxt_sen(nxt_sen),
        .nxt_idle(nxt_idle), .cfg_idle_level(cfg_idle_level),
        .nxt_word(nxt_word), .tx_data(tx_data), .tx_fs(tx_fs)
    );

    assign busy = (state_q != ST_IDLE);

    a_r4_sync_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fs |-> busy);
    a_r10_error_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!busy && !tx_fs));
    a_r9_underrun_only_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (busy && !tx_fs));
endmodule

// File: tb/sstx_top_tb.sv
// Bench: directed corner frames plus seeded random frames. After every
// transmit tick it compares the serial stream against the stream that the
// requirements predict.
module sstx_top_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, start = 1'b0;
    logic [4:0]  cfg_wlen_m1 = '0;
    logic [3:0]  cfg_words_m1 = '0, cfg_fs_base = '0, cfg_fs_ext = '0;
    logic        cfg_msb_first = 1'b0, cfg_sync_en = 1'b0, cfg_idle_level = 1'b0;
    logic [15:0] sync_word = '0;
    logic [31:0] word_data = '0;
    logic        word_valid = 1'b1;
    logic        word_req, underrun, cfg_err, busy, tx_data, tx_fs;
    int          n_cmp = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    sstx_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .cfg_wlen_m1(cfg_wlen_m1), .cfg_words_m1(cfg_words_m1),
        .cfg_fs_base(cfg_fs_base), .cfg_fs_ext(cfg_fs_ext),
        .cfg_msb_first(cfg_msb_first), .cfg_sync_en(cfg_sync_en),
        .cfg_idle_level(cfg_idle_level), .sync_word(sync_word),
        .word_data(word_data), .word_valid(word_valid),
        .word_req(word_req), .underrun(underrun), .cfg_err(cfg_err),
        .busy(busy), .tx_data(tx_data), .tx_fs(tx_fs)
    );

    task automatic chk1(input string rq, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", rq, act, exp, $time);
        end
    endtask

    // One clock with the given enable; outputs are sampled at the falling edge.
    task automatic clk_cyc(input logic t);
        tick = t;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic gap();
        int n;
        n = $urandom_range(0, 2);
        for (int g = 0; g < n; g++) clk_cyc(1'b0);
    endtask

    // Expected data bit j of a word of n bits in the given order.
    function automatic logic exp_data(input logic [31:0] w, input int n, input int j, input bit msb);
        return msb ? w[n-1-j] : w[j];
    endfunction

    task automatic run_frame(input int wl, input int nw, input int fb, input int fe,
                             input bit msb, input bit sen, input bit idl,
                             input logic [15:0] sw, input int ur,
                             input bit mid_chg, input bit mid_st);
        logic [31:0] wq [16];
        logic [31:0] eff;
        int L, N;
        logic e;
        for (int k = 0; k < 16; k++) wq[k] = $urandom;
        cfg_wlen_m1 = 5'(wl); cfg_words_m1 = 4'(nw);
        cfg_fs_base = 4'(fb); cfg_fs_ext = 4'(fe);
        cfg_msb_first = msb; cfg_sync_en = sen; cfg_idle_level = idl;
        sync_word = sw; word_valid = 1'b1; word_data = wq[0];
        clk_cyc(1'b0);
        chk1("R2 idle level before frame", tx_data, idl);
        chk1("R8 no request while idle", word_req, 1'b0);
        gap();
        start = 1'b1;
        clk_cyc(1'b1);
        start = 1'b0;
        if (mid_chg) begin  // R12: scramble configuration during the frame
            cfg_wlen_m1 = 5'($urandom_range(1, 31)); cfg_words_m1 = 4'($urandom);
            cfg_fs_base = 4'($urandom); cfg_fs_ext = 4'($urandom);
            cfg_msb_first = ~msb; cfg_sync_en = ~sen; cfg_idle_level = ~idl;
            sync_word = ~sw;
        end
        L = fb + 16*fe + 1;
        N = wl + 1;
        eff = '0;
        for (int i = 0; i < L; i++) begin
            if (i > 0) begin gap(); clk_cyc(1'b1); end
            chk1("R4 frame sync high", tx_fs, 1'b1);
            chk1("R3 busy in frame", busy, 1'b1);
            e = sen ? ((i < 16) ? sw[i] : idl) : idl;
            chk1("R5 line during sync pulse", tx_data, e);
            chk1("R8 request timing in sync", word_req, 1'(i == L-1));
        end
        for (int k = 0; k <= nw; k++) begin
            for (int j = 0; j < N; j++) begin
                if (j == 0) begin word_valid = (k != ur); word_data = wq[k]; end
                if (mid_st && k == 0 && j == 1) start = 1'b1;  // R11
                gap();
                clk_cyc(1'b1);
                start = 1'b0;
                word_valid = 1'b1;
                if (j == 0 && k != ur) eff = wq[k];
                chk1("R6 data bit", tx_data, exp_data(eff, N, j, msb));
                chk1("R4 frame sync low in data", tx_fs, 1'b0);
                if (j == 0) chk1("R9 underrun flag", underrun, 1'(k == ur));
                chk1("R8 request timing in data", word_req, 1'((j == N-1) && (k < nw)));
            end
        end
        cfg_wlen_m1 = 5'(wl); cfg_words_m1 = 4'(nw);
        cfg_fs_base = 4'(fb); cfg_fs_ext = 4'(fe);
        cfg_msb_first = msb; cfg_sync_en = sen; cfg_idle_level = idl; sync_word = sw;
        gap();
        clk_cyc(1'b1);
        chk1("R7 sync low after frame", tx_fs, 1'b0);
        chk1("R7 not busy after frame", busy, 1'b0);
        chk1("R2 idle level after frame", tx_data, idl);
        for (int r = 0; r < 3; r++) begin
            clk_cyc(1'b1);
            chk1("R11 no extra frame", busy, 1'b0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_P * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) clk_cyc(1'b0);
        rst_n = 1'b1;
        clk_cyc(1'b0);
        chk1("R1 reset sync", tx_fs, 1'b0);
        chk1("R1 reset busy", busy, 1'b0);
        chk1("R1 reset request", word_req, 1'b0);
        chk1("R1 reset underrun", underrun, 1'b0);
        chk1("R1 reset error", cfg_err, 1'b0);
        cfg_idle_level = 1'b1; clk_cyc(1'b0);
        chk1("R2 idle follows high", tx_data, 1'b1);
        cfg_idle_level = 1'b0; clk_cyc(1'b0);
        chk1("R2 idle follows low", tx_data, 1'b0);

        run_frame(7, 1, 2, 0, 1'b0, 1'b1, 1'b1, 16'hA5C3, -1, 1'b0, 1'b0);
        run_frame(4, 2, 0, 0, 1'b1, 1'b0, 1'b0, 16'h0000, -1, 1'b0, 1'b0);
        run_frame(31, 0, 3, 1, 1'b1, 1'b1, 1'b1, 16'h3C96, -1, 1'b0, 1'b0);
        run_frame(1, 3, 1, 0, 1'b0, 1'b1, 1'b0, 16'hFFFF, 2, 1'b0, 1'b0);
        run_frame(9, 2, 5, 0, 1'b1, 1'b0, 1'b1, 16'h1234, 1, 1'b1, 1'b1);
        run_frame(15, 15, 15, 15, 1'b0, 1'b1, 1'b0, 16'h8001, 15, 1'b0, 1'b0);

        // R10: zero data length is refused
        cfg_wlen_m1 = '0; cfg_idle_level = 1'b1;
        start = 1'b1; clk_cyc(1'b1); start = 1'b0;
        chk1("R10 error pulse", cfg_err, 1'b1);
        chk1("R10 no frame sync", tx_fs, 1'b0);
        chk1("R10 not busy", busy, 1'b0);
        chk1("R10 line idle", tx_data, 1'b1);
        clk_cyc(1'b1);
        chk1("R10 error is one clock", cfg_err, 1'b0);
        chk1("R10 still no frame", busy, 1'b0);

        for (int f = 0; f < 16; f++) begin
            int nw, ur;
            nw = $urandom_range(0, 5);
            ur = (nw >= 1 && ($urandom_range(0, 2) == 0)) ? $urandom_range(1, nw) : -1;
            run_frame($urandom_range(1, 31), nw, $urandom_range(0, 15), $urandom_range(0, 2),
                      1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
                      ur, 1'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule